// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one column access command into the stream of column addresses that a synchronous DRAM burst touches, one address per clock. The controller pulses a start strobe with the starting column, the direction of the access and the burst fields taken from its mode setting. The sequencer then emits each column address with a valid strobe. It raises a last-beat flag on the final address of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. They wrap within that block in linear or interleaved order. A full-page setting walks the whole row, wraps at the row end and runs until it is stopped. A single-write setting shortens every write burst to one location and leaves reads at the programmed length. A terminate request stops a burst early. A new start during a burst abandons it and begins a fresh sequence.

Top module: `sdram_burst_colseq`

## Requirements
- R1: While reset is low at a clock edge, and on the cycle after it, `col_valid_o` and `last_o` are 0.
- R2: A start sampled at a clock edge makes `col_valid_o` high on the next cycle, with `col_o` equal to the sampled start column. Each later beat appears one cycle after the one before it.
- R3: Length codes on `blen_code_i` give 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8 and 111 = full page. The unused codes 100, 101 and 110 each give a single beat.
- R4: With `ilv_i` = 0, a fixed burst of length L visits the columns of the aligned L-column block in rising order from the start column and wraps to the block base. For example, L=4 from 1 gives 1,2,3,0 and L=8 from 3 gives 3,4,5,6,7,0,1,2.
- R5: With `ilv_i` = 1, beat i of a fixed burst of length L has the block base in its upper bits and (start mod L) XOR i in its low log2(L) bits.
- R6: A full-page burst yields start+i modulo 2^COL_W on beat i. It never raises `last_o` and continues until terminate or a new start.
- R7: A full-page burst with `ilv_i` = 1 follows the rising order of R6.
- R8: When `wr_single_i` = 1, a write burst (`is_write_i` = 1) is one beat long with `last_o` high. A read burst keeps its programmed length. When `wr_single_i` = 0, writes keep their programmed length too.
- R9: `last_o` is high only on the final beat of a fixed burst. The cycle after it, `col_valid_o` is 0 unless a new start was sampled on that edge.
- R10: A terminate sampled during a burst makes `col_valid_o` 0 on the next cycle. A terminate sampled while idle has no effect. A start sampled on the same edge as a terminate wins.
- R11: A start sampled during a burst discards the remaining beats and begins the new sequence on the next cycle.
- R12: Changes on the column, direction, length, order and single-write inputs during a burst do not alter it. These inputs are captured only at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a burst with the fields below |
| start_col_i | input | COL_W | Starting column |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| blen_code_i | input | 3 | Burst length code (R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = linear order |
| wr_single_i | input | 1 | 1 = writes access a single location |
| term_i | input | 1 | Stop the running burst |
| col_o | output | COL_W | Column address of the current beat, 0 when idle |
| col_valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The properties treat `start_i` and `term_i` as synchronous strobes that are sampled only at rising edges. They also assume that the column width is at least 3 bits, so that an 8-beat block fits inside a row. The stimulus changes every input only on falling edges. It uses the default 10-bit column, so the full-page wrap from column 1023 to 0 falls inside a short terminated burst. When the bench tests the priority of start over terminate, it asserts both strobes together on purpose. Every other burst it drives is legal as a command sequence.

// File: rtl/sdb_pkg.sv
// Package: shared constants for the burst column sequencer.
// Assumes: the 3-bit burst length code follows the R3 encoding.
package sdb_pkg;
    localparam logic [2:0] BLC_ONE  = 3'b000;
    localparam logic [2:0] BLC_TWO  = 3'b001;
    localparam logic [2:0] BLC_FOUR = 3'b010;
    localparam logic [2:0] BLC_EIGHT = 3'b011;
    localparam logic [2:0] BLC_PAGE = 3'b111;
endpackage

// File: rtl/sdb_mode_decode.sv
// Module: sdb_mode_decode
// Turns the length code, the order bit and the single-write setting into a
// block mask (length-1, or all ones for full page), a full-page flag and the
// interleave flag that takes effect.
// Assumes: COL_W >= 3. Unused codes decode to a single beat.
module sdb_mode_decode
    import sdb_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       blen_code,
    input  logic             ilv_req,
    input  logic             is_write,
    input  logic             wr_single,
    output logic [COL_W-1:0] mask,
    output logic             cont,
    output logic             ilv
);
    // Decodes the length and then applies the single-write override.
    always_comb begin
        mask = '0;
        cont = 1'b0;
        case (blen_code)
            BLC_TWO:   mask = COL_W'(1);
            BLC_FOUR:  mask = COL_W'(3);
            BLC_EIGHT: mask = COL_W'(7);
            BLC_PAGE: begin
                mask = '1;
                cont = 1'b1;
            end
            default:   mask = '0;
        endcase
        if (is_write && wr_single) begin
            mask = '0;
            cont = 1'b0;
        end
        ilv = ilv_req && !cont;
    end
endmodule

// File: rtl/sdb_beat_ctrl.sv
// Module: sdb_beat_ctrl
// Holds the burst-active state and the beat index. It captures the mask and
// the full-page flag at start and flags the final beat of a fixed burst.
// Assumes: start has priority over terminate on the same edge.
module sdb_beat_ctrl #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  logic [COL_W-1:0] mask_in,
    input  logic             cont_in,
    output logic             active,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] mask_q,
    output logic             last
);
    logic cont_q;

    // Final beat: the index has reached the block mask and the burst is fixed.
    always_comb last = active && !cont_q && (cnt == mask_q);

    // Beat sequencing: load on start, stop on terminate or last, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            mask_q <= '0;
            cont_q <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            mask_q <= mask_in;
            cont_q <= cont_in;
        end else if (term) begin
            active <= 1'b0;
        end else if (active) begin
            if (last) active <= 1'b0;
            else      cnt <= cnt + COL_W'(1);
        end
    end
endmodule

// File: rtl/sdb_addr_map.sv
// Module: sdb_addr_map
// Captures the start column and the order at start. It maps the beat index
// to a column that stays inside the aligned block chosen by the mask.
// Assumes: the mask is a run of low ones (block size is a power of two).
module sdb_addr_map #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             ilv_in,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] base_q;
    logic             ilv_q;
    logic [COL_W-1:0] offs;

    // Captures the burst origin and the order when a burst starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ilv_q  <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            ilv_q  <= ilv_in;
        end
    end

    // Interleaved uses XOR and linear uses a sum; both keep only the in-block bits.
    always_comb begin
        offs = ilv_q ? (base_q ^ cnt) : (base_q + cnt);
        col  = (base_q & ~mask) | (offs & mask);
    end
endmodule

// File: rtl/sdram_burst_colseq.sv
// Module: sdram_burst_colseq (top)
// Produces one column address per clock for a read or write burst. The first
// beat appears the cycle after the start strobe.
// Assumes: the strobes are synchronous and all inputs change away from the clock edge.
module sdram_burst_colseq #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             is_write_i,
    input  logic [2:0]       blen_code_i,
    input  logic             ilv_i,
    input  logic             wr_single_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_valid_o,
    output logic             last_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_cont;
    logic             dec_ilv;
    logic             act;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] run_mask;
    logic             fin;
    logic [COL_W-1:0] col_raw;

    sdb_mode_decode #(.COL_W(COL_W)) u_dec (
        .blen_code (blen_code_i),
        .ilv_req   (ilv_i),
        .is_write  (is_write_i),
        .wr_single (wr_single_i),
        .mask      (dec_mask),
        .cont      (dec_cont),
        .ilv       (dec_ilv)
    );

    sdb_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .term    (term_i),
        .mask_in (dec_mask),
        .cont_in (dec_cont),
        .active  (act),
        .cnt     (beat_idx),
        .mask_q  (run_mask),
        .last    (fin)
    );

    sdb_addr_map #(.COL_W(COL_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .start_col (start_col_i),
        .ilv_in    (dec_ilv),
        .cnt       (beat_idx),
        .mask      (run_mask),
        .col       (col_raw)
    );

    // Output stage: drive the column to zero when no burst is running.
    always_comb begin
        col_valid_o = act;
        last_o      = fin;
        col_o       = act ? col_raw : '0;
    end
endmodule

// File: rtl/sdb_colseq_chk.sv
// Module: sdb_colseq_chk
// Temporal checks at the ports of the sequencer, attached with bind.
module sdb_colseq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             col_valid_o,
    input logic             last_o
);
    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_valid_o && col_o == $past(start_col_i)));

    // R2
    beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && !last_o && !start_i && !term_i) |=> (col_valid_o && !$stable(col_o)));

    // R9
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> col_valid_o);

    // R9
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !col_valid_o);

    // R10
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> !col_valid_o);
endmodule

bind sdram_burst_colseq sdb_colseq_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .col_valid_o (col_valid_o),
    .last_o      (last_o)
);

// File: tb/sdram_burst_colseq_tb_top.sv
// Scoreboard bench: kick() pushes the expected beats and the monitor pops them.
module sdram_burst_colseq_tb_top;
    localparam int COL_W = 10;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             is_write_i = 1'b0;
    logic [2:0]       blen_code_i = 3'b000;
    logic             ilv_i = 1'b0;
    logic             wr_single_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             col_valid_o;
    logic             last_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    col;
        bit    last;
        string req;
    } beat_t;
    beat_t exp_q[$];

    always #4 clk = ~clk;

    sdram_burst_colseq #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .is_write_i(is_write_i), .blen_code_i(blen_code_i), .ilv_i(ilv_i),
        .wr_single_i(wr_single_i), .term_i(term_i), .col_o(col_o),
        .col_valid_o(col_valid_o), .last_o(last_o)
    );

    // Model: len 0 means full page.
    function automatic int ref_col(int base, int i, int len, bit ilv);
        int blk;
        int off;
        if (len == 0) return (base + i) % NCOL;
        blk = base - (base % len);
        off = base % len;
        if (ilv) return blk + (off ^ i);
        return blk + ((off + i) % len);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive a start at the current falling edge and queue the first 'seen' beats.
    task automatic kick(int c, bit wr, logic [2:0] code, bit ilv, bit single,
                        int len, int seen, string req);
        start_i     = 1'b1;
        start_col_i = c[COL_W-1:0];
        is_write_i  = wr;
        blen_code_i = code;
        ilv_i       = ilv;
        wr_single_i = single;
        for (int i = 0; i < seen; i++) begin
            beat_t b;
            b.col  = ref_col(c, i, len, ilv);
            b.last = (len != 0) && (i == len - 1);
            b.req  = req;
            exp_q.push_back(b);
        end
        @(negedge clk);
        start_i = 1'b0;
        term_i  = 1'b0;
    endtask

    task automatic settle(int n, string req);
        repeat (n) @(negedge clk);
        check(col_valid_o == 1'b0, req, "valid after end", int'(col_valid_o), 0);
        check(exp_q.size() == 0, req, "beats missing", exp_q.size(), 0);
    endtask

    task automatic term_after(int k);
        repeat (k - 1) @(negedge clk);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
    endtask

    // Monitor: compares every valid beat with the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && col_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected beat col", int'(col_o), -1);
                end else begin
                    beat_t b;
                    b = exp_q.pop_front();
                    check(int'(col_o) == b.col, b.req, "col", int'(col_o), b.col);
                    check(last_o == b.last, b.req, "last", int'(last_o), int'(b.last));
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(col_valid_o == 1'b0, "R1", "valid in reset", int'(col_valid_o), 0);
        check(last_o == 1'b0, "R1", "last in reset", int'(last_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 linear wrap examples
        kick(1, 0, 3'b010, 0, 0, 4, 4, "R4");
        settle(4, "R4");
        kick(3, 0, 3'b011, 0, 0, 8, 8, "R4");
        settle(8, "R4");
        // R3 lengths 2 and 1, and unused codes
        kick(5, 0, 3'b001, 0, 0, 2, 2, "R3");
        settle(2, "R3");
        kick(9, 0, 3'b000, 0, 0, 1, 1, "R3");
        settle(1, "R3");
        kick(6, 0, 3'b101, 0, 0, 1, 1, "R3");
        settle(1, "R3");
        kick(14, 0, 3'b110, 0, 0, 1, 1, "R3");
        settle(1, "R3");
        // R5 interleaved
        kick(5, 0, 3'b011, 1, 0, 8, 8, "R5");
        settle(8, "R5");
        kick(42, 0, 3'b010, 1, 0, 4, 4, "R5");
        settle(4, "R5");
        // R6 full page wrap at row end, stopped by terminate
        kick(1020, 0, 3'b111, 0, 0, 0, 8, "R6");
        term_after(8);
        settle(0, "R6");
        // R7 full page with interleave requested
        kick(1021, 0, 3'b111, 1, 0, 0, 6, "R7");
        term_after(6);
        settle(0, "R7");
        // R8 single-write setting
        kick(4, 1, 3'b011, 0, 1, 1, 1, "R8");
        settle(1, "R8");
        kick(4, 0, 3'b010, 0, 1, 4, 4, "R8");
        settle(4, "R8");
        kick(12, 1, 3'b010, 0, 0, 4, 4, "R8");
        settle(4, "R8");
        kick(100, 1, 3'b111, 0, 1, 1, 1, "R8");
        settle(1, "R8");
        // R10 terminate mid burst, while idle, and together with start
        kick(16, 0, 3'b011, 0, 0, 8, 3, "R10");
        term_after(3);
        settle(0, "R10");
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        settle(1, "R10");
        term_i = 1'b1;
        kick(30, 0, 3'b001, 0, 0, 2, 2, "R10");
        settle(2, "R10");
        // R11 restart mid burst
        kick(40, 0, 3'b011, 0, 0, 8, 3, "R11");
        repeat (2) @(negedge clk);
        kick(77, 0, 3'b010, 1, 0, 4, 4, "R11");
        settle(4, "R11");
        // R9 back-to-back bursts keep valid high across the boundary
        kick(8, 0, 3'b010, 0, 0, 4, 4, "R9");
        repeat (3) @(negedge clk);
        kick(19, 0, 3'b001, 0, 0, 2, 2, "R9");
        settle(2, "R9");
        // R12 input changes during a burst are ignored
        kick(2, 0, 3'b011, 0, 0, 8, 8, "R12");
        start_col_i = 10'd500;
        blen_code_i = 3'b111;
        ilv_i       = 1'b1;
        is_write_i  = 1'b1;
        wr_single_i = 1'b1;
        settle(8, "R12");
        // R1 reset in the middle of a burst
        kick(200, 0, 3'b111, 0, 0, 0, 3, "R1");
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(col_valid_o == 1'b0, "R1", "valid after reset", int'(col_valid_o), 0);
        check(last_o == 1'b0, "R1", "last after reset", int'(last_o), 0);
        exp_q.delete();
        rst_n = 1'b1;
        settle(2, "R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule